// File: doc/BRIEF.md
# DDR I/Q Sample Port Framer

This block is the baseband-side logic of a double-data-rate source-synchronous sample port that moves 12-bit two's complement I/Q samples across a 6-bit differential bus. Double-data-rate capture is modelled as two bus words per clock. The `_a` word belongs to the first edge of the clock and the `_b` word to the second edge. A frame line travels with the words on each edge.

The transmit half takes a set of I/Q pairs, one pair per channel, through a valid/ready strobe. It splits each sample into a high and a low half and sends the halves as a framed burst of 2×NUM_CH clocks. The receive half locks onto the incoming frame and rebuilds the samples. It raises a per-channel valid strobe for each sample pair it rebuilds, and it pulses an error line when the framing breaks. Each half has its own bus, so one port only transmits and the other only receives. A per-channel enable removes a channel from use while its slots stay in the burst.

Top module: `iqp_ddr_framer`

## Requirements
- R1: A set occupies 2×NUM_CH clocks, and channel 0 comes first. For channel c, clock 2c carries I[11:6] on the `_a` word and Q[11:6] on the `_b` word. Clock 2c+1 carries I[5:0] on `_a` and Q[5:0] on `_b`. Bit 5 of every word is the most significant bit of its half.
- R2: Both frame bits of a clock carry the same level. The frame is high for the first NUM_CH clocks of a set and low for the remaining NUM_CH clocks.
- R3: `tx_ready` is high when the transmitter is idle and on the last clock of a set, and low on every other clock of a set. A set offered with `tx_valid` while `tx_ready` is high begins on the next clock. An accept on the last clock leaves no gap between the two sets.
- R4: An idle transmitter drives both words to zero and both frame bits low.
- R5: The words of a channel whose `chan_on` bit was low when its set was accepted are sent as zero. The frame pattern of the set does not change.
- R6: The receiver starts a set on a clock whose `_a` frame bit is high when the previous `_b` frame bit was low. One clock after the low-half clock of channel c, it pulses `rx_valid[c]` and presents the rebuilt I and Q on channel c's lanes. Every 12-bit code passes through unchanged, including 0x800 and 0x7FF.
- R7: `rx_valid[c]` never rises for a channel whose `chan_on` bit is low, although that channel's slots are still received.
- R8: A clock whose two frame bits differ pulses `rx_err` on the next clock and drops the set in progress.
- R9: A frame rise before the last clock of the current set pulses `rx_err`. The receiver then starts a new set on that rise and delivers the samples of the new set.
- R10: Inside a set, a frame level that differs from the R2 pattern pulses `rx_err` and drops the rest of the set, with no valid strobe for the unfinished channel.
- R11: While reset is held, `tx_ready` is high, the transmit words and frame bits are zero, and `rx_valid` and `rx_err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock; one clock equals two bus words |
| rst_n | input | 1 | Active-low synchronous reset |
| chan_on | input | NUM_CH | Per-channel enable for both directions |
| tx_valid | input | 1 | A transmit sample set is offered |
| tx_ready | output | 1 | A transmit set can be accepted this clock |
| tx_i | input | NUM_CH×12 | Transmit I samples, channel c at [12c+11:12c] |
| tx_q | input | NUM_CH×12 | Transmit Q samples, same packing |
| tx_word_a | output | 6 | Transmit word on the first edge |
| tx_word_b | output | 6 | Transmit word on the second edge |
| tx_frame_a | output | 1 | Transmit frame on the first edge |
| tx_frame_b | output | 1 | Transmit frame on the second edge |
| rx_word_a | input | 6 | Receive word on the first edge |
| rx_word_b | input | 6 | Receive word on the second edge |
| rx_frame_a | input | 1 | Receive frame on the first edge |
| rx_frame_b | input | 1 | Receive frame on the second edge |
| rx_valid | output | NUM_CH | Per-channel strobe for a rebuilt pair |
| rx_i | output | NUM_CH×12 | Rebuilt I samples, channel c at [12c+11:12c] |
| rx_q | output | NUM_CH×12 | Rebuilt Q samples, same packing |
| rx_err | output | 1 | One-clock pulse for a framing violation |

## Verification
The assertions check on every cycle the rules that tie one clock to the next. An accepted set raises the frame on the following clock. A frame rise always follows an accept. A split frame is always reported. At most one channel strobes per clock, and a disabled channel never strobes. Only the bench scenarios can show that the halves reach the right lanes and bit positions, including the extreme codes. The same holds for sets sent back to back with no gap, for zero-filled inactive slots, and for the recovery after each kind of framing fault. A loopback scoreboard and directly driven faulty frames cover these cases.

// File: rtl/iqp_pkg.sv
package iqp_pkg;
   // index width that never collapses to zero bits
   function automatic int idx_bits(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction
endpackage

// File: rtl/iqp_tx_split.sv
module iqp_tx_split #(
   parameter int WORD_W = 6,
   parameter int NUM_CH = 2
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [NUM_CH-1:0]          chan_on,
   input  logic                       in_valid,
   output logic                       in_ready,
   input  logic [NUM_CH*2*WORD_W-1:0] in_i,
   input  logic [NUM_CH*2*WORD_W-1:0] in_q,
   output logic [WORD_W-1:0]          word_a,
   output logic [WORD_W-1:0]          word_b,
   output logic                       frame_a,
   output logic                       frame_b
);
   localparam int SAMP_W = 2 * WORD_W;
   localparam int SLOT_N = 2 * NUM_CH;
   localparam int SLOT_W = iqp_pkg::idx_bits(SLOT_N);
   localparam logic [SLOT_W-1:0] LAST = SLOT_W'(SLOT_N - 1);

   logic                       busy;
   logic [SLOT_W-1:0]          slot;
   logic [NUM_CH*SAMP_W-1:0]   hold_i, hold_q;
   logic [NUM_CH-1:0]          hold_on;
   logic                       accept;
   logic                       at_last;

   logic [WORD_W-1:0] i_hi [NUM_CH];
   logic [WORD_W-1:0] i_lo [NUM_CH];
   logic [WORD_W-1:0] q_hi [NUM_CH];
   logic [WORD_W-1:0] q_lo [NUM_CH];

   assign at_last  = (slot == LAST);
   assign in_ready = !busy || at_last;
   assign accept   = in_valid && in_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy    <= 1'b0;
         slot    <= '0;
         hold_i  <= '0;
         hold_q  <= '0;
         hold_on <= '0;
      end else if (accept) begin
         busy    <= 1'b1;
         slot    <= '0;
         hold_i  <= in_i;
         hold_q  <= in_q;
         hold_on <= chan_on;
      end else if (busy) begin
         if (at_last) busy <= 1'b0;
         else         slot <= slot + 1'b1;
      end
   end

   // split every held sample into its two halves
   for (genvar c = 0; c < NUM_CH; c++) begin : g_split
      assign i_hi[c] = hold_i[c*SAMP_W+WORD_W +: WORD_W];
      assign i_lo[c] = hold_i[c*SAMP_W        +: WORD_W];
      assign q_hi[c] = hold_q[c*SAMP_W+WORD_W +: WORD_W];
      assign q_lo[c] = hold_q[c*SAMP_W        +: WORD_W];
   end

   always_comb begin
      word_a = '0;
      word_b = '0;
      for (int c = 0; c < NUM_CH; c++) begin
         if (busy && hold_on[c] && ((slot >> 1) == SLOT_W'(c))) begin
            word_a = slot[0] ? i_lo[c] : i_hi[c];
            word_b = slot[0] ? q_lo[c] : q_hi[c];
         end
      end
   end

   assign frame_a = busy && (slot < SLOT_W'(NUM_CH));
   assign frame_b = frame_a;

   // R3: an accepted set opens with the frame high on the next clock
   a_r3_accept_opens: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> (frame_a && frame_b));
   // R2: the frame only rises on the clock after an accept
   a_r2_rise_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(frame_a) |-> $past(in_valid && in_ready));
endmodule

// File: rtl/iqp_rx_join.sv
module iqp_rx_join #(
   parameter int WORD_W = 6,
   parameter int NUM_CH = 2
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [NUM_CH-1:0]          chan_on,
   input  logic [WORD_W-1:0]          word_a,
   input  logic [WORD_W-1:0]          word_b,
   input  logic                       frame_a,
   input  logic                       frame_b,
   output logic [NUM_CH-1:0]          out_valid,
   output logic [NUM_CH*2*WORD_W-1:0] out_i,
   output logic [NUM_CH*2*WORD_W-1:0] out_q,
   output logic                       frame_err
);
   localparam int SAMP_W = 2 * WORD_W;
   localparam int SLOT_N = 2 * NUM_CH;
   localparam int SLOT_W = iqp_pkg::idx_bits(SLOT_N);
   localparam logic [SLOT_W-1:0] LAST = SLOT_W'(SLOT_N - 1);

   logic              prev_fb;
   logic              inset, inset_n;
   logic [SLOT_W-1:0] slot, slot_n, nxt, cap_slot;
   logic              rise, split, at_end, exp_lvl, take, err_n;

   assign rise    = frame_a && !prev_fb;
   assign split   = frame_a ^ frame_b;
   assign at_end  = (slot == LAST);
   assign nxt     = slot + 1'b1;
   assign exp_lvl = (nxt < SLOT_W'(NUM_CH));

   always_comb begin
      take     = 1'b0;
      err_n    = 1'b0;
      inset_n  = inset;
      slot_n   = slot;
      cap_slot = slot;
      if (split) begin
         err_n   = 1'b1;
         inset_n = 1'b0;
      end else if (rise) begin
         err_n    = inset && !at_end;
         inset_n  = 1'b1;
         slot_n   = '0;
         cap_slot = '0;
         take     = 1'b1;
      end else if (inset && !at_end) begin
         if (frame_a != exp_lvl) begin
            err_n   = 1'b1;
            inset_n = 1'b0;
         end else begin
            slot_n   = nxt;
            cap_slot = nxt;
            take     = 1'b1;
         end
      end else begin
         inset_n = 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prev_fb   <= 1'b0;
         inset     <= 1'b0;
         slot      <= '0;
         frame_err <= 1'b0;
      end else begin
         prev_fb   <= frame_b;
         inset     <= inset_n;
         slot      <= slot_n;
         frame_err <= err_n;
      end
   end

   for (genvar c = 0; c < NUM_CH; c++) begin : g_lane
      logic [WORD_W-1:0] hi_i, hi_q;
      logic [SAMP_W-1:0] smp_i, smp_q;
      logic              vld;
      logic              mine;
      assign mine = take && ((cap_slot >> 1) == SLOT_W'(c));
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            hi_i  <= '0;
            hi_q  <= '0;
            smp_i <= '0;
            smp_q <= '0;
            vld   <= 1'b0;
         end else begin
            vld <= 1'b0;
            if (mine && !cap_slot[0]) begin
               hi_i <= word_a;
               hi_q <= word_b;
            end else if (mine) begin
               smp_i <= {hi_i, word_a};
               smp_q <= {hi_q, word_b};
               vld   <= chan_on[c];
            end
         end
      end
      assign out_valid[c]                = vld;
      assign out_i[c*SAMP_W +: SAMP_W]   = smp_i;
      assign out_q[c*SAMP_W +: SAMP_W]   = smp_q;
   end

   // R8: a clock with disagreeing frame bits is always reported
   a_r8_split_flag: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n && (frame_a != frame_b)) |-> frame_err);
   // R7: a disabled channel never strobes
   a_r7_quiet_channel: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid & ~$past(chan_on)) == '0);
   // R6: channels finish on distinct clocks
   a_r6_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(out_valid));
endmodule

// File: rtl/iqp_ddr_framer.sv
module iqp_ddr_framer #(
   parameter int WORD_W = 6,
   parameter int NUM_CH = 2
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [NUM_CH-1:0]          chan_on,
   input  logic                       tx_valid,
   output logic                       tx_ready,
   input  logic [NUM_CH*2*WORD_W-1:0] tx_i,
   input  logic [NUM_CH*2*WORD_W-1:0] tx_q,
   output logic [WORD_W-1:0]          tx_word_a,
   output logic [WORD_W-1:0]          tx_word_b,
   output logic                       tx_frame_a,
   output logic                       tx_frame_b,
   input  logic [WORD_W-1:0]          rx_word_a,
   input  logic [WORD_W-1:0]          rx_word_b,
   input  logic                       rx_frame_a,
   input  logic                       rx_frame_b,
   output logic [NUM_CH-1:0]          rx_valid,
   output logic [NUM_CH*2*WORD_W-1:0] rx_i,
   output logic [NUM_CH*2*WORD_W-1:0] rx_q,
   output logic                       rx_err
);
   if (NUM_CH < 1 || NUM_CH > 2) begin : g_bad_ch
      $error("iqp_ddr_framer: NUM_CH must be 1 or 2");
   end
   if (WORD_W < 2) begin : g_bad_w
      $error("iqp_ddr_framer: WORD_W must be at least 2");
   end

   iqp_tx_split #(.WORD_W(WORD_W), .NUM_CH(NUM_CH)) u_tx (
      .clk      (clk),
      .rst_n    (rst_n),
      .chan_on  (chan_on),
      .in_valid (tx_valid),
      .in_ready (tx_ready),
      .in_i     (tx_i),
      .in_q     (tx_q),
      .word_a   (tx_word_a),
      .word_b   (tx_word_b),
      .frame_a  (tx_frame_a),
      .frame_b  (tx_frame_b)
   );

   iqp_rx_join #(.WORD_W(WORD_W), .NUM_CH(NUM_CH)) u_rx (
      .clk       (clk),
      .rst_n     (rst_n),
      .chan_on   (chan_on),
      .word_a    (rx_word_a),
      .word_b    (rx_word_b),
      .frame_a   (rx_frame_a),
      .frame_b   (rx_frame_b),
      .out_valid (rx_valid),
      .out_i     (rx_i),
      .out_q     (rx_q),
      .frame_err (rx_err)
   );
endmodule

// File: tb/iqp_ddr_framer_bench.sv
module iqp_ddr_framer_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  chan_on = 2'b11;
   logic        tx_valid = 1'b0;
   logic        tx_ready;
   logic [23:0] tx_i = '0, tx_q = '0;
   logic [5:0]  tx_word_a, tx_word_b;
   logic        tx_frame_a, tx_frame_b;
   logic        loop = 1'b1;
   logic [5:0]  drv_a = '0, drv_b = '0;
   logic        drv_fa = 1'b0, drv_fb = 1'b0;
   logic [5:0]  rx_word_a, rx_word_b;
   logic        rx_frame_a, rx_frame_b;
   logic [1:0]  rx_valid;
   logic [23:0] rx_i, rx_q;
   logic        rx_err;
   int          checks = 0;
   int          errors = 0;
   logic [24:0] sb [$];

   always #10 clk = ~clk;

   assign rx_word_a  = loop ? tx_word_a  : drv_a;
   assign rx_word_b  = loop ? tx_word_b  : drv_b;
   assign rx_frame_a = loop ? tx_frame_a : drv_fa;
   assign rx_frame_b = loop ? tx_frame_b : drv_fb;

   iqp_ddr_framer #(.WORD_W(6), .NUM_CH(2)) u_iqp_ddr_framer (
      .clk(clk), .rst_n(rst_n), .chan_on(chan_on),
      .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_i(tx_i), .tx_q(tx_q),
      .tx_word_a(tx_word_a), .tx_word_b(tx_word_b),
      .tx_frame_a(tx_frame_a), .tx_frame_b(tx_frame_b),
      .rx_word_a(rx_word_a), .rx_word_b(rx_word_b),
      .rx_frame_a(rx_frame_a), .rx_frame_b(rx_frame_b),
      .rx_valid(rx_valid), .rx_i(rx_i), .rx_q(rx_q), .rx_err(rx_err));

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual %h expected %h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic push(input int ch, input logic [11:0] i, input logic [11:0] q);
      sb.push_back({ch[0], i, q});
   endtask

   // scoreboard monitor (R6, R7)
   always @(negedge clk) begin
      if (rst_n) begin
         for (int c = 0; c < 2; c++) begin
            if (rx_valid[c]) begin
               logic [24:0] got;
               got = {c[0], rx_i[c*12 +: 12], rx_q[c*12 +: 12]};
               checks++;
               if (sb.size() == 0) begin
                  errors++;
                  $display("FAIL R7 unexpected strobe actual %h expected none", got);
               end else begin
                  logic [24:0] want;
                  want = sb.pop_front();
                  if (got !== want) begin
                     errors++;
                     $display("FAIL R6 rebuilt pair actual %h expected %h", got, want);
                  end
               end
            end
         end
      end
   end

   function automatic logic [11:0] gen(input int x);
      return 12'(x * 1103 + 77);
   endfunction

   // sends n sets back to back through the transmitter (loopback into receiver)
   task automatic tx_run(input int n, input int seed);
      logic [11:0] ii [2];
      logic [11:0] qq [2];
      for (int k = 0; k < n; k++) begin
         if (seed == 0 && k == 0) begin
            ii[0] = 12'h800; qq[0] = 12'h7FF; ii[1] = 12'h000; qq[1] = 12'hFFF;
         end else begin
            ii[0] = gen(seed + 4*k); qq[0] = gen(seed + 4*k + 1);
            ii[1] = gen(seed + 4*k + 2); qq[1] = gen(seed + 4*k + 3);
         end
         tx_i = {ii[1], ii[0]};
         tx_q = {qq[1], qq[0]};
         tx_valid = 1'b1;
         for (int c = 0; c < 2; c++) if (chan_on[c]) push(c, ii[c], qq[c]);
         @(posedge clk);
         for (int s = 0; s < 4; s++) begin
            int ch;
            bit lo, act;
            logic [5:0] ea, eb;
            @(negedge clk);
            ch  = s / 2;
            lo  = (s % 2) == 1;
            act = chan_on[ch];
            ea  = act ? (lo ? ii[ch][5:0] : ii[ch][11:6]) : 6'h00;
            eb  = act ? (lo ? qq[ch][5:0] : qq[ch][11:6]) : 6'h00;
            chk(tx_word_a === ea, act ? "R1 word_a" : "R5 word_a", 32'(tx_word_a), 32'(ea));
            chk(tx_word_b === eb, act ? "R1 word_b" : "R5 word_b", 32'(tx_word_b), 32'(eb));
            chk({tx_frame_a, tx_frame_b} === ((s < 2) ? 2'b11 : 2'b00), "R2 frame",
                32'({tx_frame_a, tx_frame_b}), (s < 2) ? 32'h3 : 32'h0);
            chk(tx_ready === (s == 3), "R3 ready", 32'(tx_ready), 32'(s == 3));
            if (s == 3 && k == n - 1) tx_valid = 1'b0;
         end
      end
   endtask

   task automatic rx_step(input logic [5:0] a, input logic [5:0] b, input logic fa, input logic fb);
      drv_a = a; drv_b = b; drv_fa = fa; drv_fb = fb;
      @(negedge clk);
   endtask

   task automatic idle_chk;
      chk(tx_word_a === 6'h00 && tx_word_b === 6'h00, "R4 idle words",
          32'({tx_word_a, tx_word_b}), 32'h0);
      chk(tx_frame_a === 1'b0 && tx_frame_b === 1'b0, "R4 idle frame",
          32'({tx_frame_a, tx_frame_b}), 32'h0);
   endtask

   initial begin
      #(20 * 100000);
      checks++;
      errors++;
      $display("FAIL watchdog expired actual hung expected done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [11:0] ai, aq, bi, bq, ci, cq, di, dq;
      repeat (3) @(negedge clk);
      // R11 reset state
      chk(tx_ready === 1'b1, "R11 ready", 32'(tx_ready), 32'h1);
      chk({tx_word_a, tx_word_b, tx_frame_a, tx_frame_b} === 14'h0, "R11 tx outputs",
          32'({tx_word_a, tx_word_b, tx_frame_a, tx_frame_b}), 32'h0);
      chk(rx_valid === 2'b00 && rx_err === 1'b0, "R11 rx outputs", 32'({rx_valid, rx_err}), 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      idle_chk();

      // R1 R2 R3 R6: corners plus back-to-back sets, both channels on
      tx_run(3, 0);
      @(negedge clk);
      idle_chk();
      repeat (3) @(negedge clk);
      chk(sb.size() == 0, "R6 all pairs delivered", 32'(sb.size()), 32'h0);

      // R5 R7: one channel disabled, then the other
      chan_on = 2'b01;
      tx_run(2, 50);
      repeat (4) @(negedge clk);
      chan_on = 2'b10;
      tx_run(1, 90);
      repeat (4) @(negedge clk);
      chk(sb.size() == 0, "R7 queue after partial sets", 32'(sb.size()), 32'h0);
      chan_on = 2'b11;

      // receiver fault handling, driven directly
      loop = 1'b0;
      rx_step(6'h00, 6'h00, 1'b0, 1'b0);
      rx_step(6'h00, 6'h00, 1'b0, 1'b0);
      // R8 split frame
      rx_step(6'h15, 6'h2A, 1'b1, 1'b0);
      chk(rx_err === 1'b1, "R8 split frame flagged", 32'(rx_err), 32'h1);
      rx_step(6'h00, 6'h00, 1'b0, 1'b0);
      chk(rx_err === 1'b0, "R8 flag is a pulse", 32'(rx_err), 32'h0);
      // R10 early fall inside a set
      ai = 12'hA5C; aq = 12'h3C1;
      rx_step(ai[11:6], aq[11:6], 1'b1, 1'b1);
      chk(rx_err === 1'b0, "R10 good start", 32'(rx_err), 32'h0);
      rx_step(ai[5:0], aq[5:0], 1'b0, 1'b0);
      chk(rx_err === 1'b1, "R10 early fall flagged", 32'(rx_err), 32'h1);
      chk(rx_valid === 2'b00, "R10 dropped pair", 32'(rx_valid), 32'h0);
      rx_step(6'h00, 6'h00, 1'b0, 1'b0);
      rx_step(6'h00, 6'h00, 1'b0, 1'b0);
      chk(rx_err === 1'b0 && rx_valid === 2'b00, "R10 stays quiet", 32'({rx_valid, rx_err}), 32'h0);
      // R9 rise in the middle of a set, then realign
      bi = 12'h123; bq = 12'h456; ci = 12'h789;
      rx_step(bi[11:6], bq[11:6], 1'b1, 1'b1);
      push(0, bi, bq);
      rx_step(bi[5:0], bq[5:0], 1'b1, 1'b1);
      rx_step(ci[11:6], 6'h11, 1'b0, 1'b0);
      di = 12'hFED; dq = 12'h801; cq = 12'h0F0;
      rx_step(di[11:6], dq[11:6], 1'b1, 1'b1);
      chk(rx_err === 1'b1, "R9 mid-set rise flagged", 32'(rx_err), 32'h1);
      push(0, di, dq);
      rx_step(di[5:0], dq[5:0], 1'b1, 1'b1);
      rx_step(ci[11:6], cq[11:6], 1'b0, 1'b0);
      chk(rx_err === 1'b0, "R9 realigned set clean", 32'(rx_err), 32'h0);
      push(1, ci, cq);
      rx_step(ci[5:0], cq[5:0], 1'b0, 1'b0);
      rx_step(6'h00, 6'h00, 1'b0, 1'b0);
      chk(rx_err === 1'b0, "R9 no late flag", 32'(rx_err), 32'h0);
      repeat (2) @(negedge clk);
      chk(sb.size() == 0, "R9 realigned pairs delivered", 32'(sb.size()), 32'h0);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule